// File: doc/BRIEF.md
# AES Byte-Slice Round Unit

This unit performs one byte-wide step of an AES round for a 32-bit or 64-bit integer datapath. It takes one byte of the second operand, chosen by a 2-bit index, and passes it through the forward or inverse S-box. It can then widen that byte into the column word that MixColumns or InvMixColumns would produce from it. The word is rotated to the byte lane of the index and XORed into the low word of the first operand. Four such operations with the four indices accumulate a full column of a round into one register. The 32-bit result is sign-extended to the register width.

A request is taken on the input when `in_valid` and `in_ready` are both high at a rising edge. The result sits in a single output register and `out_valid` rises on the next edge. The result is handed over on any edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, `in_ready` is low and the output holds steady. When the output register is empty, or is being drained in the same cycle, `in_ready` is high, so a downstream that always takes results gets one result per cycle.

Top module: `aes_slice_round`

## Requirements
- R1: The substituted byte is bits [8*k+7 : 8*k] of `in_rs2`, where k is the value of `in_idx`.
- R2: With `in_enc`=1 and `in_mix`=0, the pre-rotation word is the forward AES S-box of the byte in bits [7:0] with zeros above (S-box(0x00)=0x63, S-box(0x53)=0xED).
- R3: With `in_enc`=0 and `in_mix`=0, the pre-rotation word is the inverse AES S-box of the byte in bits [7:0] with zeros above.
- R4: With `in_enc`=1 and `in_mix`=1, the word carries, from least to most significant byte, 2·s, s, s and 3·s over GF(2^8) modulo 0x11B, where s is the forward S-box output.
- R5: With `in_enc`=0 and `in_mix`=1, the word carries, from least to most significant byte, 0x0E·s, 0x09·s, 0x0D·s and 0x0B·s, where s is the inverse S-box output.
- R6: The word is rotated left by 8*k bits and XORed with `in_rs1[31:0]`. Bits of `in_rs1` above bit 31 have no effect. With `in_mix`=0, every byte of the result other than lane k equals the same byte of `in_rs1`.
- R7: `out_data` is the 32-bit result sign-extended to XLEN bits (XLEN is 32 or 64).
- R8: A request accepted at an edge appears on `out_data` with `out_valid`=1 after that same edge, one cycle of latency.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_valid` and `out_data` stay unchanged.
- R10: A synchronous active-high `rst` clears `out_valid`, which is 0 after any edge where `rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_rs1 | input | XLEN | Accumulator operand |
| in_rs2 | input | XLEN | Operand supplying the byte to substitute |
| in_idx | input | 2 | Byte lane index k |
| in_enc | input | 1 | 1 = forward S-box and MixColumns, 0 = inverse |
| in_mix | input | 1 | 1 = expand into mixed column word, 0 = byte only |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | XLEN | Sign-extended result |

## Verification
The bench targets the four byte lanes, using known S-box constants and known mixed columns. A wrong lane select or a wrong rotation amount puts these values in the wrong byte. It pairs negative 32-bit results with `in_rs1` values whose upper bits are set, to check R6 and R7. A design that passed through the upper half of `in_rs1`, or zero-extended, would show a wrong upper word. Back-pressure runs with a random `out_ready` against a scoreboard, so a dropped, repeated or overwritten result shows up as a mismatch or an order error. A reset that lands while a result is stalled must clear `out_valid`.

// File: rtl/aes_slice_pkg.sv
package aes_slice_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam logic [7:0] AFF_FWD_C = 8'h63;
  localparam logic [7:0] AFF_INV_C = 8'h05;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_dbl(p);
    end
    return acc;
  endfunction

  // a^254 equals the multiplicative inverse; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] acc;
    pw  = a;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gf_mul(pw, pw);
      acc = gf_mul(acc, pw);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int unsigned n);
    logic [15:0] d;
    d = {a, a} << n;
    return d[15:8];
  endfunction

endpackage

// File: rtl/aes_slice_sbox.sv
module aes_slice_sbox
  import aes_slice_pkg::*;
(
  input  logic [7:0] byte_in,
  input  logic       fwd,
  output logic [7:0] byte_out
);

  logic [7:0] fwd_res;
  logic [7:0] inv_pre;
  logic [7:0] inv_res;

  always_comb begin
    logic [7:0] t;
    t       = gf_inv(byte_in);
    fwd_res = t ^ rotl8(t, 1) ^ rotl8(t, 2) ^ rotl8(t, 3) ^ rotl8(t, 4) ^ AFF_FWD_C;
  end

  always_comb begin
    inv_pre = rotl8(byte_in, 1) ^ rotl8(byte_in, 3) ^ rotl8(byte_in, 6) ^ AFF_INV_C;
    inv_res = gf_inv(inv_pre);
  end

  assign byte_out = fwd ? fwd_res : inv_res;

endmodule

// File: rtl/aes_slice_mix.sv
module aes_slice_mix
  import aes_slice_pkg::*;
(
  input  logic [7:0]  s_in,
  input  logic        fwd,
  input  logic        mix,
  output logic [31:0] word
);

  always_comb begin
    if (!mix) begin
      word = {24'h000000, s_in};
    end else if (fwd) begin
      word = {gf_mul(s_in, 8'h03), s_in, s_in, gf_dbl(s_in)};
    end else begin
      word = {gf_mul(s_in, 8'h0b), gf_mul(s_in, 8'h0d),
              gf_mul(s_in, 8'h09), gf_mul(s_in, 8'h0e)};
    end
  end

  // R4 R5: a nonzero byte never expands to an all-zero word and zero stays zero
  always_comb begin
    a_r5_zero_iff_zero: assert ((s_in == 8'h00) == (word == 32'h0))
      else $error("mixed word zero-ness does not follow substituted byte");
  end

endmodule

// File: rtl/aes_slice_place.sv
module aes_slice_place (
  input  logic [31:0] word,
  input  logic [31:0] acc,
  input  logic [1:0]  lane,
  output logic [31:0] res
);

  logic [4:0]  shamt;
  logic [63:0] dbl;

  assign shamt = {lane, 3'b000};
  assign dbl   = {word, word} << shamt;
  assign res   = dbl[63:32] ^ acc;

endmodule

// File: rtl/aes_slice_round.sv
module aes_slice_round #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [1:0]      in_idx,
  input  logic            in_enc,
  input  logic            in_mix,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);

  localparam int unsigned EXT_W = XLEN - 32;

  logic [7:0]      sel_byte;
  logic [7:0]      sub_byte;
  logic [31:0]     col_word;
  logic [31:0]     res32;
  logic [XLEN-1:0] res_ext;
  logic            take;

  assign sel_byte = in_rs2[{in_idx, 3'b000} +: 8];

  aes_slice_sbox u_sbox (
    .byte_in (sel_byte),
    .fwd     (in_enc),
    .byte_out(sub_byte)
  );

  aes_slice_mix u_mix (
    .s_in(sub_byte),
    .fwd (in_enc),
    .mix (in_mix),
    .word(col_word)
  );

  aes_slice_place u_place (
    .word(col_word),
    .acc (in_rs1[31:0]),
    .lane(in_idx),
    .res (res32)
  );

  generate
    if (XLEN > 32) begin : g_sext
      assign res_ext = {{EXT_W{res32[31]}}, res32};
    end else begin : g_plain
      assign res_ext = res32;
    end
  endgenerate

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= res_ext;
  end

  a_r10_reset_clears: assert property (@(posedge clk) rst |=> !out_valid)
    else $error("out_valid set after reset");

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted request not presented next cycle");

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("stalled result changed or vanished");

  a_r6_other_lanes_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_mix) |=>
      (((out_data[31:0] ^ $past(in_rs1[31:0])) & ~(32'hFF << {$past(in_idx), 3'b000})) == 32'h0))
    else $error("unmixed result touched a byte outside the selected lane");

endmodule

// File: tb/aes_slice_round_bench.sv
module aes_slice_round_bench;

  localparam int unsigned XLEN = 64;
  localparam time CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG_CYC = 100000;

  typedef struct {
    logic [XLEN-1:0] exp;
    string           tag;
  } sb_item_t;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic            in_ready;
  logic [XLEN-1:0] in_rs1;
  logic [XLEN-1:0] in_rs2;
  logic [1:0]      in_idx;
  logic            in_enc;
  logic            in_mix;
  logic            out_valid;
  logic            out_ready;
  logic [XLEN-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  bit rand_stall = 1'b0;
  sb_item_t sb_q[$];

  logic [7:0] t_fwd [256];
  logic [7:0] t_inv [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_slice_round #(.XLEN(XLEN)) u_aes_slice_round (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_idx(in_idx),
    .in_enc(in_enc), .in_mix(in_mix),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] x;
    logic [7:0] y;
    r = 0; x = a; y = b;
    while (y != 0) begin
      if (y[0]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return r;
  endfunction

  function automatic logic [XLEN-1:0] ref_calc(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                               input logic [1:0] k, input logic e, input logic m);
    logic [7:0]  byt;
    logic [7:0]  s;
    logic [31:0] w;
    logic [31:0] r;
    byt = b[8*k +: 8];
    s = e ? t_fwd[byt] : t_inv[byt];
    if (!m) w = {24'h0, s};
    else if (e) w = {b_mul(s, 8'h03), s, s, b_mul(s, 8'h02)};
    else w = {b_mul(s, 8'h0b), b_mul(s, 8'h0d), b_mul(s, 8'h09), b_mul(s, 8'h0e)};
    for (int i = 0; i < k; i++) w = {w[23:0], w[31:24]};
    r = w ^ a[31:0];
    return {{(XLEN-32){r[31]}}, r};
  endfunction

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv;
      logic [7:0] o;
      iv = 0;
      for (int y = 1; y < 256; y++)
        if (b_mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8] ^ iv[(i+7)%8] ^ AFF_BIT(i);
      t_fwd[x] = o;
    end
    for (int x = 0; x < 256; x++) t_inv[t_fwd[x]] = 8'(x);
  endtask

  function automatic logic AFF_BIT(input int i);
    logic [7:0] c;
    c = 8'h63;
    return c[i];
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [1:0] k,
                      input logic e, input logic m, input logic [XLEN-1:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_rs1 = a; in_rs2 = b; in_idx = k; in_enc = e; in_mix = m;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_ref(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [1:0] k,
                          input logic e, input logic m, input string tag);
    send(a, b, k, e, m, ref_calc(a, b, k, e, m), tag);
  endtask

  // monitor: compares every handed-over result against the queue head
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL R8: actual unexpected result %h expected none", out_data);
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          check(it.tag, out_data, it.exp);
        end
      end
    end
  end

  // random back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (rand_stall) out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYC; c++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] held;
    rst = 1'b1; in_valid = 1'b0; in_rs1 = 0; in_rs2 = 0; in_idx = 0;
    in_enc = 0; in_mix = 0; out_ready = 1'b1;
    build_tables();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset state", {63'b0, out_valid}, 64'd1 - 64'd1);
    rst = 1'b0;

    // known constants
    send(64'h0, 64'h0, 2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_0063, "R2 sbox(00) lane0");
    send(64'h0, 64'h0053_0000, 2'd2, 1'b1, 1'b0, 64'h0000_0000_00ED_0000, "R1 R2 sbox(53) lane2");
    send(64'h0, 64'h0, 2'd3, 1'b1, 1'b0, 64'h0000_0000_6300_0000, "R6 lane3 rotation");
    send(64'h0, 64'h0000_0000_0000_0063, 2'd0, 1'b0, 1'b0, 64'h0, "R3 invsbox(63)");
    send(64'h0, 64'h0, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_A563_63C6, "R4 R7 mixed 63 negative");
    send(64'h0, 64'h0000_0000_0000_7C00, 2'd1, 1'b0, 1'b1, 64'h0000_0000_0D09_0E0B, "R5 invmix of 01 lane1");
    send(64'hDEAD_BEEF_0000_0000, 64'h0, 2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_0063, "R6 rs1 upper ignored");
    send(64'h1234_5678_8000_0000, 64'hFF00_0000_0000_0000, 2'd0, 1'b1, 1'b0,
         64'hFFFF_FFFF_8000_0063, "R7 sign extend from rs1 bit31");
    repeat (3) @(negedge clk);

    // R8: lone request, result present right after the accepting edge
    send_ref(64'h0000_0000_0102_0304, 64'h0000_0000_A0B0_C0D0, 2'd1, 1'b1, 1'b1, "R8 latency data");
    #1;
    check("R8 out_valid after accept", {63'b0, out_valid}, 64'd1);
    repeat (3) @(negedge clk);

    // R9: stall hold
    out_ready = 1'b0;
    send_ref(64'h0, 64'h0000_0000_1122_3344, 2'd2, 1'b0, 1'b1, "R9 released value");
    @(negedge clk);
    held = out_data;
    repeat (3) @(negedge clk);
    #2;
    check("R9 valid held", {63'b0, out_valid}, 64'd1);
    check("R9 in_ready low", {63'b0, in_ready}, 64'd0);
    check("R9 data stable", out_data, held);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);

    // random with back-pressure
    rand_stall = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic e;
      logic m;
      string tg;
      e = 1'($urandom_range(0, 1));
      m = 1'($urandom_range(0, 1));
      tg = e ? (m ? "R1 R4 R6 R7 random" : "R1 R2 R6 R7 random")
             : (m ? "R1 R5 R6 R7 random" : "R1 R3 R6 R7 random");
      send_ref({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom_range(0, 3)), e, m, tg);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    rand_stall = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    for (int w = 0; w < 50 && sb_q.size() != 0; w++) @(negedge clk);
    check("R9 queue drained", 64'(sb_q.size()), 64'd0);

    // R10: reset while a result is stalled
    out_ready = 1'b0;
    send_ref(64'h0, 64'h0, 2'd0, 1'b1, 1'b0, "R10 discarded");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears stalled valid", {63'b0, out_valid}, 64'd0);
    sb_q.delete();
    rst = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule